// File: doc/BRIEF.md
# Multi-Mode 16-bit PWM Timer

This block is a 16-bit counter whose behaviour is chosen by a 4-bit mode code. The code selects one of several counting styles:

- a free-running up-counter;
- clear-on-compare;
- single-slope (fast) PWM;
- dual-slope PWM. Dual-slope comes in two variants, phase-correct and phase-and-frequency-correct.

For each mode the code also fixes three things: where the counting ceiling (TOP) comes from, when a newly written compare value takes effect, and at which count the overflow pulse fires. TOP can be a fixed constant, the active compare value, or an externally supplied capture value.

The counter advances only on clock edges where the count-enable tick is high, so an external prescaler sets the rate. Compare writes always land in a shadow register. The shadow register is copied into the active compare register either immediately or at the update point the mode selects, which keeps PWM periods glitch-free. The block produces one waveform output driven by compare matches, and an overflow pulse that lasts one cycle.

Top module: `pwm_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following are all set to 0 at that edge: the count, the active compare value, the shadow compare value, `wave_o` and `ovf_o`. The counting direction is set to up.
- R2: On an edge where `tick_i` is 0, the count and `wave_o` do not change, and the active compare value changes only through an immediate-mode write.
- R3: Mode 0 counts up by one per tick, wrapping from 0xFFFF to 0. The overflow pulse comes from the tick taken at 0xFFFF.
- R4: Mode 4 (TOP = active compare value) and mode 12 (TOP = capture input) count up and return to 0 on the tick taken at TOP. The overflow pulse comes from the tick taken at 0xFFFF.
- R5: Fast PWM modes count 0..TOP and wrap to 0. The overflow pulse comes from the tick taken at TOP. TOP is 0x00FF, 0x01FF and 0x03FF in modes 5, 6 and 7, the capture input in mode 14, and the active compare value in mode 15.
- R6: Dual-slope modes 1, 2, 3, 8, 9, 10 and 11 count up to TOP, then down to 0, without repeating either end value. The overflow pulse comes from every tick taken at count 0.
  - TOP in modes 1, 2 and 3 is 0x00FF, 0x01FF and 0x03FF.
  - TOP in modes 8 and 10 is the capture input.
  - TOP in modes 9 and 11 is the compare value.
  - A TOP of 0 holds the count at 0.
- R7: A compare write (`cmp_wr_i`) always loads the shadow register. The active compare register is loaded as follows, according to the mode:
  - in modes 0, 4 and 12, it takes the written data on the same edge;
  - in modes 5, 6, 7, 8, 9, 14 and 15, it takes the shadow value on the tick taken at count 0;
  - in modes 1, 2, 3, 10 and 11, it takes the shadow value on the tick taken at TOP.
- R8: In fast PWM modes, the tick taken at TOP sets `wave_o` to 1. Otherwise, the tick taken at a count equal to the active compare value clears `wave_o` to 0.
- R9: In dual-slope modes, a tick taken at a count equal to the active compare value behaves as follows:
  - while counting up, it clears `wave_o`;
  - while counting down, it sets `wave_o`.
- R10: In modes 0, 4 and 12, a tick taken at a count equal to the active compare value toggles `wave_o`.
- R11: Mode 13 is reserved. In this mode, ticks leave the count and `wave_o` unchanged, no overflow pulse fires, and compare writes reach only the shadow register.
- R12: `ovf_o` is a registered pulse, high for exactly the one cycle after the qualifying tick edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Count enable; the timer acts only on edges where it is high |
| mode_i | input | 4 | Mode code 0..15 |
| cmp_wr_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 16 | Compare write data |
| cap_val_i | input | 16 | Capture value, used as TOP in modes 8, 10, 12 and 14 |
| count_o | output | 16 | Current count |
| cmp_o | output | 16 | Active compare value |
| wave_o | output | 1 | Compare-match waveform |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
The embedded properties assume the following about the inputs:
- `mode_i` and `cap_val_i` are known, defined values.
- `mode_i` changes only while reset is held, so a direction bit or active compare value left over from another mode never meets a new ceiling partway through a period.

The stimulus respects these assumptions:
- It loads the mode and the capture value under reset.
- It drives every input at the falling clock edge.
- It issues compare writes only while `tick_i` is low, so each write lands on an edge of its own, apart from any counting.

// File: rtl/pwm_timer_pkg.sv
// Package: shared types for the multi-mode PWM timer.
// Assumes: counter width of at least 10 bits, so that the fixed ceilings fit.
package pwm_timer_pkg;

    // Counting style selected by the mode code.
    typedef enum logic [2:0] {
        KIND_HOLD,
        KIND_FREE,
        KIND_CLR,
        KIND_FAST,
        KIND_DUAL
    } cnt_kind_t;

    // Source of the counting ceiling.
    typedef enum logic [2:0] {
        TOP_MAX,
        TOP_FIX8,
        TOP_FIX9,
        TOP_FIX10,
        TOP_CMP,
        TOP_CAP
    } top_src_t;

    // Moment at which the shadow compare value becomes active.
    typedef enum logic [1:0] {
        UPD_NOW,
        UPD_TOP,
        UPD_BOT,
        UPD_NEVER
    } upd_pt_t;

    // Count point that raises the overflow pulse.
    typedef enum logic [1:0] {
        FLG_MAX,
        FLG_TOP,
        FLG_BOT,
        FLG_NONE
    } flg_pt_t;

    // Full decoded configuration for one mode code.
    typedef struct packed {
        cnt_kind_t kind;
        top_src_t  top_src;
        upd_pt_t   upd;
        flg_pt_t   flg;
    } mode_cfg_t;

endpackage

// File: rtl/pwm_mode_decode.sv
// Module: pwm_mode_decode
// Maps the 4-bit mode code onto counting style, ceiling source,
// compare update point and overflow point.
// Assumes: purely combinational; code 13 is reserved and decodes to hold.
module pwm_mode_decode
    import pwm_timer_pkg::*;
(
    input  logic [3:0] mode_i,
    output mode_cfg_t  cfg_o
);

    // Table lookup of the per-mode configuration.
    always_comb begin
        case (mode_i)
            4'd0:    cfg_o = '{KIND_FREE, TOP_MAX,   UPD_NOW,   FLG_MAX};
            4'd1:    cfg_o = '{KIND_DUAL, TOP_FIX8,  UPD_TOP,   FLG_BOT};
            4'd2:    cfg_o = '{KIND_DUAL, TOP_FIX9,  UPD_TOP,   FLG_BOT};
            4'd3:    cfg_o = '{KIND_DUAL, TOP_FIX10, UPD_TOP,   FLG_BOT};
            4'd4:    cfg_o = '{KIND_CLR,  TOP_CMP,   UPD_NOW,   FLG_MAX};
            4'd5:    cfg_o = '{KIND_FAST, TOP_FIX8,  UPD_BOT,   FLG_TOP};
            4'd6:    cfg_o = '{KIND_FAST, TOP_FIX9,  UPD_BOT,   FLG_TOP};
            4'd7:    cfg_o = '{KIND_FAST, TOP_FIX10, UPD_BOT,   FLG_TOP};
            4'd8:    cfg_o = '{KIND_DUAL, TOP_CAP,   UPD_BOT,   FLG_BOT};
            4'd9:    cfg_o = '{KIND_DUAL, TOP_CMP,   UPD_BOT,   FLG_BOT};
            4'd10:   cfg_o = '{KIND_DUAL, TOP_CAP,   UPD_TOP,   FLG_BOT};
            4'd11:   cfg_o = '{KIND_DUAL, TOP_CMP,   UPD_TOP,   FLG_BOT};
            4'd12:   cfg_o = '{KIND_CLR,  TOP_CAP,   UPD_NOW,   FLG_MAX};
            4'd14:   cfg_o = '{KIND_FAST, TOP_CAP,   UPD_BOT,   FLG_TOP};
            4'd15:   cfg_o = '{KIND_FAST, TOP_CMP,   UPD_BOT,   FLG_TOP};
            default: cfg_o = '{KIND_HOLD, TOP_MAX,   UPD_NEVER, FLG_NONE};
        endcase
    end

endmodule

// File: rtl/pwm_counter.sv
// Module: pwm_counter
// Holds the count and the dual-slope direction, and produces the
// end-of-range indications and the registered overflow pulse.
// Assumes: top_i is stable across the tick it is compared against;
// synchronous active-low reset.
module pwm_counter
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  cnt_kind_t        kind_i,
    input  flg_pt_t          flg_i,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_up_o,
    output logic             at_top_o,
    output logic             at_bot_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dir_q, dir_d;
    logic             flg_hit;

    // End-of-range indications against the current ceiling.
    always_comb begin
        at_top_o = (cnt_q == top_i);
        at_bot_o = (cnt_q == '0);
    end

    // Next count and direction for the selected counting style.
    always_comb begin
        cnt_d = cnt_q;
        dir_d = 1'b1;
        case (kind_i)
            KIND_FREE: cnt_d = cnt_q + ONE;
            KIND_CLR,
            KIND_FAST: cnt_d = at_top_o ? '0 : cnt_q + ONE;
            KIND_DUAL: begin
                if (top_i == '0) begin
                    cnt_d = '0;
                    dir_d = 1'b1;
                end else if (dir_q) begin
                    if (cnt_q >= top_i) begin
                        cnt_d = cnt_q - ONE;
                        dir_d = 1'b0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                        dir_d = 1'b1;
                    end
                end else begin
                    if (at_bot_o) begin
                        cnt_d = ONE;
                        dir_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                        dir_d = 1'b0;
                    end
                end
            end
            default: begin
                cnt_d = cnt_q;
                dir_d = dir_q;
            end
        endcase
    end

    // Count point that qualifies the overflow pulse.
    always_comb begin
        case (flg_i)
            FLG_MAX: flg_hit = (cnt_q == CNT_MAX);
            FLG_TOP: flg_hit = at_top_o;
            FLG_BOT: flg_hit = at_bot_o;
            default: flg_hit = 1'b0;
        endcase
    end

    // Count, direction and overflow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b1;
            ovf_o <= 1'b0;
        end else begin
            ovf_o <= tick_i && flg_hit;
            if (tick_i) begin
                cnt_q <= cnt_d;
                dir_q <= dir_d;
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign dir_up_o = dir_q;

    // R2: without a tick the count is frozen.
    p_idle_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));

    // R3: free mode advances by one per tick.
    p_free_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && kind_i == KIND_FREE) |=> (cnt_q == $past(cnt_q) + ONE));

    // R4: clear-on-compare returns to zero after TOP.
    p_clr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && kind_i == KIND_CLR && cnt_q == top_i) |=> (cnt_q == '0));

    // R6: dual slope leaves bottom towards one.
    p_dual_bottom_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && kind_i == KIND_DUAL && top_i != '0 && cnt_q == '0)
        |=> (cnt_q == ONE));

    // R11: the reserved mode holds the count.
    p_hold_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == KIND_HOLD) |=> $stable(cnt_q));

    // R12: the overflow pulse always follows a tick edge.
    p_ovf_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(tick_i));

endmodule

// File: rtl/pwm_compare.sv
// Module: pwm_compare
// Shadow and active compare registers; the shadow register takes every
// write, and the active register loads at the point the mode selects.
// Assumes: at_top_i/at_bot_i reflect the count sampled on the same edge.
module pwm_compare
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  upd_pt_t          upd_i,
    input  logic             at_top_i,
    input  logic             at_bot_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cmp_o
);

    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] active_q;
    logic             load_now;
    logic             load_shadow;

    // Decide whether this edge copies data into the active register.
    always_comb begin
        load_now    = (upd_i == UPD_NOW) && wr_i;
        load_shadow = tick_i && (((upd_i == UPD_TOP) && at_top_i) ||
                                 ((upd_i == UPD_BOT) && at_bot_i));
    end

    // Shadow and active compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_i) begin
                shadow_q <= wdata_i;
            end
            if (load_now) begin
                active_q <= wdata_i;
            end else if (load_shadow) begin
                active_q <= shadow_q;
            end
        end
    end

    assign cmp_o = active_q;

    // R7: the active value moves only on a write in immediate mode or at an update point.
    p_cmp_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && upd_i == UPD_NOW) && !(tick_i && (at_top_i || at_bot_i))
        |=> $stable(active_q));

    // R11: the reserved mode never loads the active value.
    p_cmp_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i == UPD_NEVER) |=> $stable(active_q));

endmodule

// File: rtl/pwm_wave.sv
// Module: pwm_wave
// Drives the compare-match waveform for each counting style.
// Assumes: dir_up_i is the direction in force for the current count.
module pwm_wave
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  cnt_kind_t        kind_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             at_top_i,
    input  logic             dir_up_i,
    output logic             wave_o
);

    logic wave_q, wave_d;
    logic match;

    // Next waveform level for the selected counting style.
    always_comb begin
        match  = (cnt_i == cmp_i);
        wave_d = wave_q;
        case (kind_i)
            KIND_FAST: begin
                if (at_top_i) begin
                    wave_d = 1'b1;
                end else if (match) begin
                    wave_d = 1'b0;
                end
            end
            KIND_DUAL: begin
                if (match) begin
                    wave_d = !dir_up_i;
                end
            end
            KIND_FREE,
            KIND_CLR: begin
                if (match) begin
                    wave_d = !wave_q;
                end
            end
            default: wave_d = wave_q;
        endcase
    end

    // Waveform register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
        end else if (tick_i) begin
            wave_q <= wave_d;
        end
    end

    assign wave_o = wave_q;

    // R2: the waveform only moves on a tick.
    p_idle_wave_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(wave_q));

    // R11: the reserved mode holds the waveform.
    p_hold_wave_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == KIND_HOLD) |=> $stable(wave_q));

    // R8: in fast mode a tick at TOP leaves the output high.
    p_fast_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && kind_i == KIND_FAST && at_top_i) |=> wave_q);

endmodule

// File: rtl/pwm_timer.sv
// Module: pwm_timer (top)
// Multi-mode timer: decodes the mode, selects the ceiling, and ties
// together counter, compare registers and waveform generator.
// Assumes: mode_i is changed only while rst_n is low; synchronous
// active-low reset; CNT_W of at least 10.
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [3:0]       mode_i,
    input  logic             cmp_wr_i,
    input  logic [CNT_W-1:0] cmp_wdata_i,
    input  logic [CNT_W-1:0] cap_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic             wave_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] TOP_8B  = CNT_W'(255);
    localparam logic [CNT_W-1:0] TOP_9B  = CNT_W'(511);
    localparam logic [CNT_W-1:0] TOP_10B = CNT_W'(1023);
    localparam logic [CNT_W-1:0] TOP_ALL = {CNT_W{1'b1}};

    mode_cfg_t        cfg;
    logic [CNT_W-1:0] top_val;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp_act;
    logic             dir_up;
    logic             at_top;
    logic             at_bot;

    pwm_mode_decode u_dec (
        .mode_i (mode_i),
        .cfg_o  (cfg)
    );

    // Ceiling selection for the decoded source.
    always_comb begin
        case (cfg.top_src)
            TOP_FIX8:  top_val = TOP_8B;
            TOP_FIX9:  top_val = TOP_9B;
            TOP_FIX10: top_val = TOP_10B;
            TOP_CMP:   top_val = cmp_act;
            TOP_CAP:   top_val = cap_val_i;
            default:   top_val = TOP_ALL;
        endcase
    end

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .kind_i   (cfg.kind),
        .flg_i    (cfg.flg),
        .top_i    (top_val),
        .cnt_o    (cnt),
        .dir_up_o (dir_up),
        .at_top_o (at_top),
        .at_bot_o (at_bot),
        .ovf_o    (ovf_o)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .upd_i    (cfg.upd),
        .at_top_i (at_top),
        .at_bot_i (at_bot),
        .wr_i     (cmp_wr_i),
        .wdata_i  (cmp_wdata_i),
        .cmp_o    (cmp_act)
    );

    pwm_wave #(.CNT_W(CNT_W)) u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .kind_i   (cfg.kind),
        .cnt_i    (cnt),
        .cmp_i    (cmp_act),
        .at_top_i (at_top),
        .dir_up_i (dir_up),
        .wave_o   (wave_o)
    );

    assign count_o = cnt;
    assign cmp_o   = cmp_act;

    // R1: the cycle after a reset edge shows the idle state.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (count_o == '0 && cmp_o == '0 && !wave_o && !ovf_o));

endmodule

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [3:0]  mode_i = 4'd0;
    logic        cmp_wr_i = 1'b0;
    logic [15:0] cmp_wdata_i = '0;
    logic [15:0] cap_val_i = '0;
    logic [15:0] count_o;
    logic [15:0] cmp_o;
    logic        wave_o;
    logic        ovf_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwm_timer #(.CNT_W(16)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .mode_i      (mode_i),
        .cmp_wr_i    (cmp_wr_i),
        .cmp_wdata_i (cmp_wdata_i),
        .cap_val_i   (cap_val_i),
        .count_o     (count_o),
        .cmp_o       (cmp_o),
        .wave_o      (wave_o),
        .ovf_o       (ovf_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] m, input logic [15:0] cap);
        @(negedge clk);
        rst_n = 1'b0; tick_i = 1'b0; cmp_wr_i = 1'b0;
        mode_i = m; cap_val_i = cap;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_ticks(input int n);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic write_cmp(input logic [15:0] v);
        cmp_wr_i = 1'b1; cmp_wdata_i = v;
        @(negedge clk);
        cmp_wr_i = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(4'd0, 16'h0);
        chk("R1", "count", count_o, 0);
        chk("R1", "cmp",   cmp_o, 0);
        chk("R1", "wave",  wave_o, 0);
        chk("R1", "ovf",   ovf_o, 0);
    endtask

    task automatic t_normal;
        do_reset(4'd0, 16'h0);
        write_cmp(16'd3);
        chk("R7", "immediate cmp mode0", cmp_o, 3);
        run_ticks(3);
        chk("R3", "count after 3", count_o, 3);
        chk("R10", "wave before match", wave_o, 0);
        run_ticks(1);
        chk("R10", "wave toggled", wave_o, 1);
        repeat (5) @(negedge clk);
        chk("R2", "count idle", count_o, 4);
        chk("R2", "wave idle", wave_o, 1);
        run_ticks(65531);
        chk("R3", "count at max", count_o, 16'hFFFF);
        chk("R3", "no ovf before max", ovf_o, 0);
        run_ticks(1);
        chk("R3", "wrap", count_o, 0);
        chk("R3", "ovf at max", ovf_o, 1);
        @(negedge clk);
        chk("R12", "ovf one cycle", ovf_o, 0);
    endtask

    task automatic t_ctc;
        do_reset(4'd4, 16'h0);
        write_cmp(16'd5);
        chk("R4", "immediate cmp mode4", cmp_o, 5);
        run_ticks(5);
        chk("R4", "count at top", count_o, 5);
        run_ticks(1);
        chk("R4", "clear after top", count_o, 0);
        chk("R4", "no ovf in ctc", ovf_o, 0);
        do_reset(4'd12, 16'd3);
        run_ticks(4);
        chk("R4", "mode12 clear", count_o, 0);
        run_ticks(2);
        chk("R4", "mode12 count", count_o, 2);
    endtask

    task automatic t_fast;
        do_reset(4'd5, 16'h0);
        write_cmp(16'h40);
        chk("R7", "buffered not active", cmp_o, 0);
        run_ticks(1);
        chk("R7", "load at bottom", cmp_o, 16'h40);
        run_ticks(255);
        chk("R5", "fast wrap", count_o, 0);
        chk("R5", "ovf at top", ovf_o, 1);
        chk("R8", "set at top", wave_o, 1);
        run_ticks(64);
        chk("R8", "high through match count", wave_o, 1);
        run_ticks(1);
        chk("R8", "cleared after match", wave_o, 0);
        chk("R5", "count", count_o, 16'h41);
        write_cmp(16'h10);
        chk("R7", "mid period write held", cmp_o, 16'h40);
        do_reset(4'd7, 16'h0);
        run_ticks(1023);
        chk("R5", "mode7 top", count_o, 16'h3FF);
        run_ticks(1);
        chk("R5", "mode7 wrap", count_o, 0);
        do_reset(4'd14, 16'd7);
        run_ticks(7);
        chk("R5", "mode14 at top", count_o, 7);
        chk("R5", "mode14 no ovf yet", ovf_o, 0);
        run_ticks(1);
        chk("R5", "mode14 wrap", count_o, 0);
        chk("R5", "mode14 ovf", ovf_o, 1);
    endtask

    task automatic t_phase;
        do_reset(4'd1, 16'h0);
        write_cmp(16'h80);
        run_ticks(1);
        chk("R6", "ovf at bottom", ovf_o, 1);
        chk("R7", "not loaded at bottom", cmp_o, 0);
        run_ticks(254);
        chk("R6", "at top", count_o, 255);
        run_ticks(1);
        chk("R6", "turn down", count_o, 254);
        chk("R7", "load at top", cmp_o, 16'h80);
        run_ticks(126);
        chk("R9", "low before down match", wave_o, 0);
        run_ticks(1);
        chk("R9", "set on down match", wave_o, 1);
        run_ticks(127);
        chk("R6", "at bottom", count_o, 0);
        run_ticks(1);
        chk("R6", "turn up", count_o, 1);
        chk("R6", "ovf turn", ovf_o, 1);
        run_ticks(127);
        chk("R9", "high before up match", wave_o, 1);
        run_ticks(1);
        chk("R9", "cleared on up match", wave_o, 0);
        do_reset(4'd10, 16'd10);
        write_cmp(16'd3);
        run_ticks(10);
        chk("R6", "mode10 top", count_o, 10);
        chk("R7", "mode10 not yet", cmp_o, 0);
        run_ticks(1);
        chk("R6", "mode10 down", count_o, 9);
        chk("R7", "mode10 load at top", cmp_o, 3);
        run_ticks(9);
        chk("R6", "mode10 bottom", count_o, 0);
        chk("R6", "mode10 no ovf", ovf_o, 0);
        run_ticks(1);
        chk("R6", "mode10 ovf", ovf_o, 1);
        do_reset(4'd8, 16'd10);
        write_cmp(16'd3);
        run_ticks(1);
        chk("R7", "mode8 load at bottom", cmp_o, 3);
    endtask

    task automatic t_hold;
        do_reset(4'd13, 16'h0);
        write_cmp(16'd9);
        run_ticks(5);
        chk("R11", "count held", count_o, 0);
        chk("R11", "cmp untouched", cmp_o, 0);
        chk("R11", "wave held", wave_o, 0);
        chk("R11", "no ovf", ovf_o, 0);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_ctc();
        t_fast();
        t_phase();
        t_hold();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule